// File: doc/BRIEF.md
# Transfer Descriptor Splitter

This block turns a single DMA transfer request into a run of hardware descriptors. A request gives a direction, a device-side address, a host-side address, a byte length and the table slot where the first descriptor goes. The block cuts the transfer into chunks of at most 0xFFF00 bytes, which is one MiB less a 256-byte margin. It presents one descriptor per chunk on a valid/ready stream, advancing both addresses by each chunk's length.

Descriptor slots are numbered 0 to 127. Generation ends when the length runs out or when the slot numbers or the descriptor count reach the end of the table. When it ends, the block reports how many descriptors it produced and how many bytes they cover. A caller whose transfer was cut short at the table limit can then issue a new request that starts at that byte offset. Requests are taken only when the block is idle.

Top module: `desc_splitter`

## Requirements
- R1: After reset, `busy`, `dsc_valid`, `rpt_done` and `rpt_misalign` are all 0.
- R2: When `req_to_host` is 0, the source is the host address and the destination is the device address. When `req_to_host` is 1, the source is the device address and the destination is the host address.
- R3: Each chunk is the smaller of the remaining length and 0xFFF00. Source and destination addresses advance by the chunk length from one descriptor to the next.
- R4: `dsc_ctl` holds the chunk length divided by four (truncated) in bits [17:0] and the slot ID in bits [24:18]. Bits [31:25] are zero.
- R5: Slot IDs start at `req_slot` and rise by one per descriptor. The last descriptor is the one that exhausts the length, or the one in slot 127, or the 128th descriptor, whichever comes first.
- R6: A request with a length of zero, or with `req_slot` above 127, produces no descriptors. It completes with `rpt_error` = 1, a count of 0 and a byte total of 0.
- R7: `rpt_done` is high for exactly one cycle. That cycle follows the handshake of the last descriptor, or for a rejected request the cycle after acceptance. `rpt_count` and `rpt_bytes` then give the number of descriptors and the bytes they cover. `busy` is 0 in the next cycle.
- R8: `rpt_misalign` is set to 1 when an accepted request has a length that is not a multiple of four, and cleared otherwise. It holds that value until the next accepted request. Generation is not affected.
- R9: While `dsc_valid` is 1 and `dsc_ready` is 0, every descriptor output stays unchanged.
- R10: `req_start` is taken only when `busy` is 0. The first descriptor is valid in the following cycle. A `req_start` that arrives while busy has no effect on the stream or on the report.
- R11: `dsc_last` is 1 only on the final descriptor of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_to_host | input | 1 | 0: host to device, 1: device to host |
| req_dev_addr | input | 64 | Device-side start address |
| req_host_addr | input | 64 | Host-side start address |
| req_len | input | 32 | Transfer length in bytes |
| req_slot | input | 8 | First descriptor slot ID |
| busy | output | 1 | High from acceptance until the report cycle |
| dsc_valid | output | 1 | Descriptor available |
| dsc_ready | input | 1 | Consumer takes the descriptor |
| dsc_src | output | 64 | Descriptor source address |
| dsc_dst | output | 64 | Descriptor destination address |
| dsc_ctl | output | 32 | Length in words and slot ID |
| dsc_last | output | 1 | Final descriptor of the request |
| rpt_done | output | 1 | One-cycle completion pulse |
| rpt_error | output | 1 | Request was rejected |
| rpt_count | output | 8 | Descriptors produced |
| rpt_bytes | output | 32 | Bytes covered by those descriptors |
| rpt_misalign | output | 1 | Last accepted length was not a multiple of four |

## Verification
A wrong remaining length or address register shows up on the very next descriptor as a wrong source, destination or length field, so the per-cycle comparison catches it at the first handshake after the fault. A wrong slot or count register changes where the run stops: `dsc_last` appears on the wrong descriptor, or `rpt_done` arrives a cycle early or late with a wrong count. This is exposed by truncated runs that start near slot 127 and by runs from slot 0 that fill all 128 slots. Holding faults under back-pressure appear as soon as `dsc_ready` is held low for a cycle.

// File: rtl/desc_splitter.sv
module desc_splitter #(
  parameter int          ADDR_W    = 64,
  parameter int          LEN_W     = 32,
  parameter int          CTL_W     = 32,
  parameter int          SLOTS     = 128,
  parameter int          ID_SHIFT  = 18,
  parameter int unsigned MAX_CHUNK = 32'h000F_FF00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_start,
  input  logic                         req_to_host,
  input  logic [ADDR_W-1:0]            req_dev_addr,
  input  logic [ADDR_W-1:0]            req_host_addr,
  input  logic [LEN_W-1:0]             req_len,
  input  logic [$clog2(SLOTS):0]       req_slot,
  output logic                         busy,
  output logic                         dsc_valid,
  input  logic                         dsc_ready,
  output logic [ADDR_W-1:0]            dsc_src,
  output logic [ADDR_W-1:0]            dsc_dst,
  output logic [CTL_W-1:0]             dsc_ctl,
  output logic                         dsc_last,
  output logic                         rpt_done,
  output logic                         rpt_error,
  output logic [$clog2(SLOTS):0]       rpt_count,
  output logic [LEN_W-1:0]             rpt_bytes,
  output logic                         rpt_misalign
);
  localparam int ID_W = $clog2(SLOTS);
  localparam int PAD_W = CTL_W - ID_SHIFT - ID_W;
  localparam logic [LEN_W-1:0] MAXC = LEN_W'(MAX_CHUNK);
  localparam logic [ID_W-1:0]  TOP_ID = ID_W'(SLOTS - 1);
  localparam logic [ID_W:0]    TOP_CNT = (ID_W+1)'(SLOTS - 1);

  typedef enum logic [1:0] {S_IDLE, S_EMIT, S_DONE} st_t;
  st_t st_q;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  rem_q, bytes_q;
  logic [ID_W-1:0]   id_q;
  logic [ID_W:0]     cnt_q;
  logic              err_q, warn_q;

  logic [LEN_W-1:0] chunk;
  logic             fin;
  logic             take;
  logic             bad_req;

  assign chunk   = (rem_q > MAXC) ? MAXC : rem_q;
  assign fin     = (rem_q <= MAXC) || (id_q == TOP_ID) || (cnt_q == TOP_CNT);
  assign take    = (st_q == S_EMIT) && dsc_ready;
  assign bad_req = (req_len == '0) || (req_slot >= (ID_W+1)'(SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      bytes_q <= '0;
      id_q    <= '0;
      cnt_q   <= '0;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_start) begin
          warn_q  <= (req_len[1:0] != 2'b00);
          cnt_q   <= '0;
          bytes_q <= '0;
          err_q   <= bad_req;
          rem_q   <= req_len;
          id_q    <= req_slot[ID_W-1:0];
          src_q   <= req_to_host ? req_dev_addr : req_host_addr;
          dst_q   <= req_to_host ? req_host_addr : req_dev_addr;
          st_q    <= bad_req ? S_DONE : S_EMIT;
        end
        S_EMIT: if (take) begin
          src_q   <= src_q + ADDR_W'(chunk);
          dst_q   <= dst_q + ADDR_W'(chunk);
          rem_q   <= rem_q - chunk;
          bytes_q <= bytes_q + chunk;
          id_q    <= id_q + 1'b1;
          cnt_q   <= cnt_q + 1'b1;
          if (fin) st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != S_IDLE);
  assign dsc_valid    = (st_q == S_EMIT);
  assign dsc_src      = src_q;
  assign dsc_dst      = dst_q;
  assign dsc_ctl      = {{PAD_W{1'b0}}, id_q, chunk[ID_SHIFT+1:2]};
  assign dsc_last     = dsc_valid && fin;
  assign rpt_done     = (st_q == S_DONE);
  assign rpt_error    = err_q;
  assign rpt_count    = cnt_q;
  assign rpt_bytes    = bytes_q;
  assign rpt_misalign = warn_q;
endmodule

// File: rtl/desc_splitter_chk.sv
module desc_splitter_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32,
  parameter int CTL_W  = 32,
  parameter int CW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              dsc_valid,
  input logic              dsc_ready,
  input logic [ADDR_W-1:0] dsc_src,
  input logic [ADDR_W-1:0] dsc_dst,
  input logic [CTL_W-1:0]  dsc_ctl,
  input logic              dsc_last,
  input logic              rpt_done,
  input logic              rpt_error,
  input logic [CW-1:0]     rpt_count,
  input logic [LEN_W-1:0]  rpt_bytes
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_src) && $stable(dsc_dst) && $stable(dsc_ctl) && $stable(dsc_last)); // R9
  AST_CHUNK_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> dsc_ctl[17:0] <= 18'h3FFC0); // R3
  AST_ID_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && dsc_ready && !dsc_last |=> dsc_valid && (dsc_ctl[24:18] == $past(dsc_ctl[24:18]) + 7'd1)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done |=> !rpt_done && !busy); // R7
  AST_LAST_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid && dsc_ready && dsc_last |=> rpt_done && !dsc_valid); // R11
  AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_done && rpt_error |-> rpt_count == '0 && rpt_bytes == '0); // R6
  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> busy); // R10
endmodule

bind desc_splitter desc_splitter_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CTL_W(CTL_W), .CW($clog2(SLOTS)+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
  .dsc_src(dsc_src), .dsc_dst(dsc_dst), .dsc_ctl(dsc_ctl), .dsc_last(dsc_last),
  .rpt_done(rpt_done), .rpt_error(rpt_error), .rpt_count(rpt_count), .rpt_bytes(rpt_bytes)
);

// File: tb/desc_splitter_bench.sv
`timescale 1ns/1ps
module desc_splitter_bench;
  localparam longint MAXC = 64'h000F_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_to_host = 1'b0;
  logic [63:0] req_dev_addr = '0;
  logic [63:0] req_host_addr = '0;
  logic [31:0] req_len = '0;
  logic [7:0]  req_slot = '0;
  logic        dsc_ready = 1'b1;
  logic        busy, dsc_valid, dsc_last, rpt_done, rpt_error, rpt_misalign;
  logic [63:0] dsc_src, dsc_dst;
  logic [31:0] dsc_ctl, rpt_bytes;
  logic [7:0]  rpt_count;

  always #2.5 clk = ~clk;

  desc_splitter u_desc_splitter (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_to_host(req_to_host),
    .req_dev_addr(req_dev_addr), .req_host_addr(req_host_addr), .req_len(req_len),
    .req_slot(req_slot), .busy(busy), .dsc_valid(dsc_valid), .dsc_ready(dsc_ready),
    .dsc_src(dsc_src), .dsc_dst(dsc_dst), .dsc_ctl(dsc_ctl), .dsc_last(dsc_last),
    .rpt_done(rpt_done), .rpt_error(rpt_error), .rpt_count(rpt_count),
    .rpt_bytes(rpt_bytes), .rpt_misalign(rpt_misalign)
  );

  int checks = 0;
  int fails = 0;
  int ready_mode = 0;
  bit finished = 0;

  int          m_phase = 0;
  bit [63:0]   q_src[$], q_dst[$];
  bit [31:0]   q_ctl[$];
  bit          q_last[$];
  bit          m_err = 0, m_warn = 0;
  int          m_cnt = 0;
  longint      m_bytes = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic build(input bit to_host, input bit [63:0] dev, input bit [63:0] host,
                       input longint len, input int slot);
    longint rem = len;
    bit [63:0] s = to_host ? dev : host;
    bit [63:0] d = to_host ? host : dev;
    int id = slot;
    longint c;
    m_cnt = 0; m_bytes = 0;
    do begin
      c = (rem > MAXC) ? MAXC : rem;
      q_src.push_back(s); q_dst.push_back(d);
      q_ctl.push_back(32'((c >> 2) & 64'h3FFFF) | (32'(id) << 18));
      q_last.push_back(1'b0);
      m_bytes += c; m_cnt++; s += c; d += c; rem -= c; id++;
    end while (rem != 0 && id < 128 && m_cnt < 128);
    q_last[q_last.size()-1] = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_warn = 0; m_err = 0;
      q_src.delete(); q_dst.delete(); q_ctl.delete(); q_last.delete();
    end else begin
      case (m_phase)
        0: if (req_start) begin
          m_warn = (req_len[1:0] != 0);
          if (req_len == 0 || req_slot > 127) begin
            m_err = 1; m_cnt = 0; m_bytes = 0; m_phase = 2;
          end else begin
            m_err = 0;
            build(req_to_host, req_dev_addr, req_host_addr, longint'(req_len), int'(req_slot));
            m_phase = 1;
          end
        end
        1: if (dsc_ready) begin
          void'(q_src.pop_front()); void'(q_dst.pop_front());
          void'(q_ctl.pop_front()); void'(q_last.pop_front());
          if (q_src.size() == 0) m_phase = 2;
        end
        default: m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(busy == (m_phase != 0), "R10 busy", busy, m_phase != 0);
      chk(dsc_valid == (m_phase == 1), "R10 valid", dsc_valid, m_phase == 1);
      chk(rpt_done == (m_phase == 2), "R7 done", rpt_done, m_phase == 2);
      chk(rpt_misalign == m_warn, "R8 misalign", rpt_misalign, m_warn);
      if (m_phase == 1 && dsc_valid) begin
        chk(dsc_src == q_src[0], "R2 src", dsc_src, q_src[0]);
        chk(dsc_dst == q_dst[0], "R3 dst", dsc_dst, q_dst[0]);
        chk(dsc_ctl == q_ctl[0], "R4 ctl", dsc_ctl, q_ctl[0]);
        chk(dsc_last == q_last[0], "R11 last", dsc_last, q_last[0]);
      end
      if (m_phase == 2 && rpt_done) begin
        chk(rpt_error == m_err, "R6 error", rpt_error, m_err);
        chk(rpt_count == 8'(m_cnt), "R5 count", rpt_count, m_cnt);
        chk(rpt_bytes == 32'(m_bytes), "R7 bytes", rpt_bytes, m_bytes);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      dsc_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end
  end

  task automatic run(input bit to_host, input bit [63:0] dev, input bit [63:0] host,
                     input bit [31:0] len, input bit [7:0] slot);
    @(negedge clk);
    req_start = 1'b1; req_to_host = to_host; req_dev_addr = dev;
    req_host_addr = host; req_len = len; req_slot = slot;
    @(negedge clk);
    req_start = 1'b0;
    while (m_phase != 0) @(negedge clk);
  endtask

  task automatic report();
    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog expired actual=%0d expected=0", 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(dsc_valid == 0, "R1 valid", dsc_valid, 0);
    chk(rpt_done == 0, "R1 done", rpt_done, 0);
    chk(rpt_misalign == 0, "R1 misalign", rpt_misalign, 0);
    rst_n = 1'b1;
    // R2 R3 small host-to-device
    run(0, 64'h0000_0000_7000_0000, 64'h0000_0001_2340_0000, 32'h1000, 8'd0);
    // R2 R3 three chunks device-to-host
    run(1, 64'h0000_0000_7010_0000, 64'h0000_0002_0000_0000, 32'h0025_0000, 8'd5);
    // R3 exact max and max plus four
    run(0, 64'h100, 64'h200, 32'h000F_FF00, 8'd10);
    run(1, 64'h100, 64'h200, 32'h000F_FF04, 8'd20);
    // R6 rejections
    run(0, 64'h0, 64'h0, 32'h0, 8'd0);
    run(0, 64'h0, 64'h0, 32'h40, 8'd128);
    run(0, 64'h0, 64'h0, 32'h41, 8'd200);
    // R8 unaligned
    run(0, 64'h1000, 64'h8000, 32'h1003, 8'd3);
    // R5 truncation at slot 127
    run(1, 64'h0, 64'h4000_0000, 32'hFFFF_FFFC, 8'd126);
    run(0, 64'h0, 64'h4000_0000, 32'h0030_0000, 8'd127);
    // R9 back-pressure, R5 full table from slot 0
    ready_mode = 1;
    run(0, 64'h0000_0010_0000_0000, 64'h0, 32'hFFFF_FFFF, 8'd0);
    run(1, 64'h500, 64'h900, 32'h0040_0008, 8'd60);
    // R10 start while busy is ignored
    @(negedge clk);
    req_start = 1'b1; req_to_host = 1'b0; req_dev_addr = 64'hA000;
    req_host_addr = 64'hB000; req_len = 32'h0030_0000; req_slot = 8'd1;
    @(negedge clk);
    req_dev_addr = 64'hDEAD_0000; req_host_addr = 64'hBEEF_0000;
    req_len = 32'h8; req_slot = 8'd99;
    repeat (2) @(negedge clk);
    req_start = 1'b0;
    while (m_phase != 0) @(negedge clk);
    ready_mode = 0;
    run(1, 64'h40, 64'h80, 32'h4, 8'd0);
    repeat (4) @(negedge clk);
    report();
  end
endmodule